// File: doc/BRIEF.md
# USB OUT Endpoint Receive Engine

This block receives one OUT data packet at a time for a single device endpoint and stores it into a ring of receive descriptors. Each descriptor owns a fixed-size slice of a local byte memory and carries an empty flag, an interrupt enable, a ring-return flag, a byte count and three status bits. Software arms a descriptor by marking it empty. The engine fills armed descriptors in ring order and hands each one back by clearing its empty flag.

An OUT token starts a reception. The engine spends one cycle checking the descriptor at its ring pointer, and then accepts a decoded byte stream. The first stored byte is the packet's data PID. The engine does not judge the data toggle. When a slice fills, the descriptor is closed and the packet continues in the next descriptor. At the end of the packet, the engine closes the last descriptor, raises the interrupt if that descriptor allows it, and issues a handshake request. The request is ACK, NAK, STALL or nothing, chosen by a two-bit endpoint mode. It is always nothing when the packet was corrupted or could not be stored.

The byte input is a valid/ready stream. `in_ready` is high only while a packet is being taken in, after the token check. The engine never stalls once it is receiving. A beat is accepted on a rising edge with both `in_valid` and `in_ready` high. `in_eop`, `in_crc_err` and `in_stuff_err` qualify the accepted beat, and the error flags are only looked at on the last beat. Descriptors are armed through a plain write port.

Top module: `usb_out_rx_engine`

## Requirements
- R1: After reset, `in_ready` is low, all descriptors read as not empty and no update, interrupt or handshake is issued. An OUT token raises `in_ready` two clock edges later. `in_ready` falls again after the beat carrying `in_eop`.
- R2: Accepted bytes are written in arrival order into the current descriptor's slice, starting at offset 0. The data PID byte is stored at offset 0 whatever its value. Bytes are written only into a descriptor whose empty flag is set.
- R3: When the byte at the last offset of a slice (BUF_BYTES-1) is accepted without `in_eop`, that descriptor is closed. Closing means its empty flag is cleared and its length is set to BUF_BYTES. Reception then continues at offset 0 of the next descriptor.
- R4: Every descriptor close produces a one-cycle `upd_valid` pulse carrying the index, length and status. `irq` pulses in that same cycle only if the closed descriptor's interrupt enable is set.
- R5: The next descriptor after index i is index 0 if i has its ring-return flag set or i is NUM_BD-1. Otherwise it is i+1. The ring pointer persists from one packet to the next.
- R6: On the `in_eop` beat, the descriptor holding that byte is closed with its actual byte count (1..BUF_BYTES), even if its slice is not full.
- R7: `hs_valid` pulses for exactly one cycle, one clock after the accepted `in_eop` beat. For a clean, fully stored packet, the endpoint mode selects the code: mode 00 gives code 1 (ACK), 01 gives code 0 (none), 10 gives code 2 (NAK), 11 gives code 3 (STALL).
- R8: If `in_crc_err` or `in_stuff_err` is set on the last beat, the handshake code is 0. The last descriptor is closed with status bit 0 set for a CRC error and status bit 1 set for a stuffing error.
- R9: If a slice fills before the packet ends and the next descriptor is not empty, the full descriptor is closed with status bit 2 (overrun) set. The remaining bytes are accepted and discarded with no further update, and the handshake code is 0.
- R10: If the descriptor at the ring pointer is not empty when the token arrives, the whole packet is accepted and discarded. No descriptor changes and the handshake code is 0.
- R11: A packet whose last byte lands exactly on the last offset of a slice produces a single close with length BUF_BYTES. Overrun is not set even if the next descriptor is not empty, and the handshake follows the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_out | input | 1 | One-cycle pulse: OUT token addressed to this endpoint |
| in_valid | input | 1 | Byte stream beat valid |
| in_ready | output | 1 | Engine accepts a beat this cycle |
| in_data | input | 8 | Decoded packet byte |
| in_eop | input | 1 | Beat is the last byte of the packet |
| in_crc_err | input | 1 | CRC failure, qualified by the last beat |
| in_stuff_err | input | 1 | Bit-stuffing violation, qualified by the last beat |
| hs_mode | input | 2 | Endpoint receive handshake mode |
| arm_valid | input | 1 | Arm the descriptor at `arm_idx` (set empty, clear length/status) |
| arm_idx | input | IDX_W | Descriptor index to arm |
| arm_ie | input | 1 | Interrupt enable stored with the arm |
| arm_wrap | input | 1 | Ring-return flag stored with the arm |
| upd_valid | output | 1 | A descriptor was closed |
| upd_idx | output | IDX_W | Index of the closed descriptor |
| upd_len | output | LEN_W | Byte count written on close |
| upd_stat | output | 3 | Status written on close: bit0 CRC, bit1 stuffing, bit2 overrun |
| irq | output | 1 | Interrupt pulse |
| hs_valid | output | 1 | Handshake request pulse |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| bd_empty | output | NUM_BD | Empty flag of every descriptor |
| rd_idx | input | IDX_W | Read port descriptor index |
| rd_off | input | OFF_W | Read port byte offset |
| rd_data | output | 8 | Stored byte at `rd_idx`/`rd_off` |
| rd_len | output | LEN_W | Stored length of `rd_idx` |
| rd_stat | output | 3 | Stored status of `rd_idx` |

## Verification
Two events can land on the same accepted byte: the slice-full rollover and the end of the packet. That byte must close its descriptor once, and the end-of-packet path must win over the rollover lookahead. This is provoked with a 16-byte packet across two armed descriptors whose successor is not armed. The run is judged by exactly two updates, both with zero status and full length, plus a STALL handshake instead of an overrun. The opposite case is also exercised: an 11-byte packet facing a non-empty successor must produce a single update with status bit 2 and handshake code 0.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  localparam logic [1:0] HS_NONE  = 2'd0;
  localparam logic [1:0] HS_ACK   = 2'd1;
  localparam logic [1:0] HS_NAK   = 2'd2;
  localparam logic [1:0] HS_STALL = 2'd3;

  localparam int STAT_W     = 3;
  localparam int STAT_CRC   = 0;
  localparam int STAT_STUFF = 1;
  localparam int STAT_OVR   = 2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_CHECK,
    RX_STORE,
    RX_DROP
  } rx_state_e;

  // Endpoint mode to handshake code for a clean packet
  function automatic logic [1:0] mode_to_hs(input logic [1:0] mode);
    case (mode)
      2'b00:   return HS_ACK;
      2'b01:   return HS_NONE;
      2'b10:   return HS_NAK;
      default: return HS_STALL;
    endcase
  endfunction

endpackage

// File: rtl/usb_rx_bd_table.sv
module usb_rx_bd_table
  import usb_rx_pkg::*;
#(
  parameter int NUM_BD = 4,
  parameter int IDX_W  = 2,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid,
  input  logic [IDX_W-1:0]  arm_idx,
  input  logic              arm_ie,
  input  logic              arm_wrap,
  input  logic              cls_valid,
  input  logic [IDX_W-1:0]  cls_idx,
  input  logic [LEN_W-1:0]  cls_len,
  input  logic [STAT_W-1:0] cls_stat,
  output logic [NUM_BD-1:0] empty_o,
  output logic [NUM_BD-1:0] ie_o,
  output logic [NUM_BD-1:0] wrap_o,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LEN_W-1:0]  rd_len,
  output logic [STAT_W-1:0] rd_stat
);

  logic [LEN_W-1:0]  len_q  [NUM_BD];
  logic [STAT_W-1:0] stat_q [NUM_BD];

  for (genvar g = 0; g < NUM_BD; g++) begin : g_bd
    // A close by the engine outranks an arm of the same entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        empty_o[g] <= 1'b0;
        ie_o[g]    <= 1'b0;
        wrap_o[g]  <= 1'b0;
        len_q[g]   <= '0;
        stat_q[g]  <= '0;
      end else if (cls_valid && cls_idx == IDX_W'(g)) begin
        empty_o[g] <= 1'b0;
        len_q[g]   <= cls_len;
        stat_q[g]  <= cls_stat;
      end else if (arm_valid && arm_idx == IDX_W'(g)) begin
        empty_o[g] <= 1'b1;
        ie_o[g]    <= arm_ie;
        wrap_o[g]  <= arm_wrap;
        len_q[g]   <= '0;
        stat_q[g]  <= '0;
      end
    end
  end

  assign rd_len  = len_q[rd_idx];
  assign rd_stat = stat_q[rd_idx];

  AST_CLOSE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |=> !empty_o[$past(cls_idx)]); // R3

endmodule

// File: rtl/usb_rx_data_mem.sv
module usb_rx_data_mem #(
  parameter int NUM_BD    = 4,
  parameter int BUF_BYTES = 8,
  parameter int IDX_W     = 2,
  parameter int OFF_W     = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [OFF_W-1:0] w_off,
  input  logic [7:0]       w_data,
  input  logic [IDX_W-1:0] r_idx,
  input  logic [OFF_W-1:0] r_off,
  output logic [7:0]       r_data
);

  localparam int DEPTH  = NUM_BD * BUF_BYTES;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] SLICE = ADDR_W'(BUF_BYTES);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;

  assign waddr = ADDR_W'(w_idx) * SLICE + ADDR_W'(w_off);
  assign raddr = ADDR_W'(r_idx) * SLICE + ADDR_W'(r_off);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= w_data;
  end

  assign r_data = mem[raddr];

endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
  import usb_rx_pkg::*;
#(
  parameter int NUM_BD    = 4,
  parameter int BUF_BYTES = 8,
  parameter int IDX_W     = 2,
  parameter int OFF_W     = 3,
  parameter int LEN_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_out,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_eop,
  input  logic              in_crc_err,
  input  logic              in_stuff_err,
  input  logic [1:0]        hs_mode,
  input  logic [NUM_BD-1:0] bd_empty,
  input  logic [NUM_BD-1:0] bd_ie,
  input  logic [NUM_BD-1:0] bd_wrap,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [OFF_W-1:0]  mem_off,
  output logic [7:0]        mem_data,
  output logic              cls_valid,
  output logic [IDX_W-1:0]  cls_idx,
  output logic [LEN_W-1:0]  cls_len,
  output logic [STAT_W-1:0] cls_stat,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [LEN_W-1:0]  upd_len,
  output logic [STAT_W-1:0] upd_stat,
  output logic              irq,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BUF_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_BD  = IDX_W'(NUM_BD - 1);

  rx_state_e        st;
  logic [IDX_W-1:0] cur;
  logic [OFF_W-1:0] off;

  logic             acc;
  logic             store;
  logic             full;
  logic             bad;
  logic [IDX_W-1:0] nxt;
  logic             nxt_free;
  logic [1:0]       hs_sel;

  assign in_ready = (st == RX_STORE) || (st == RX_DROP);
  assign acc      = in_valid && in_ready;
  assign store    = acc && (st == RX_STORE);
  assign full     = (off == LAST_OFF);
  assign bad      = in_crc_err || in_stuff_err;

  // Ring successor and whether it can take the rest of the packet
  assign nxt      = (bd_wrap[cur] || cur == LAST_BD) ? '0 : cur + IDX_W'(1);
  assign nxt_free = bd_empty[nxt] && (nxt != cur);

  assign mem_we   = store;
  assign mem_idx  = cur;
  assign mem_off  = off;
  assign mem_data = in_data;

  assign cls_valid = store && (in_eop || full);
  assign cls_idx   = cur;
  assign cls_len   = in_eop ? (LEN_W'(off) + LEN_W'(1)) : LEN_W'(BUF_BYTES);

  always_comb begin
    cls_stat = '0;
    cls_stat[STAT_CRC]   = in_eop && in_crc_err;
    cls_stat[STAT_STUFF] = in_eop && in_stuff_err;
    cls_stat[STAT_OVR]   = !in_eop && full && !nxt_free;
  end

  always_comb begin
    if (st == RX_DROP || bad) hs_sel = HS_NONE;
    else                      hs_sel = mode_to_hs(hs_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RX_IDLE;
      cur <= '0;
      off <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (tok_out) st <= RX_CHECK;
        end
        RX_CHECK: begin
          off <= '0;
          st  <= bd_empty[cur] ? RX_STORE : RX_DROP;
        end
        RX_STORE: begin
          if (acc) begin
            if (in_eop) begin
              cur <= nxt;
              off <= '0;
              st  <= RX_IDLE;
            end else if (full) begin
              cur <= nxt;
              off <= '0;
              st  <= nxt_free ? RX_STORE : RX_DROP;
            end else begin
              off <= off + OFF_W'(1);
            end
          end
        end
        RX_DROP: begin
          if (acc && in_eop) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_idx   <= '0;
      upd_len   <= '0;
      upd_stat  <= '0;
      irq       <= 1'b0;
      hs_valid  <= 1'b0;
      hs_code   <= HS_NONE;
    end else begin
      upd_valid <= cls_valid;
      irq       <= cls_valid && bd_ie[cur];
      hs_valid  <= acc && in_eop;
      if (cls_valid) begin
        upd_idx  <= cls_idx;
        upd_len  <= cls_len;
        upd_stat <= cls_stat;
      end
      if (acc && in_eop) hs_code <= hs_sel;
    end
  end

  AST_STORE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bd_empty[mem_idx]); // R2
  AST_IRQ_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> upd_valid); // R4
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_len != '0) && (upd_len <= LEN_W'(BUF_BYTES))); // R6
  AST_HS_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop) |=> hs_valid); // R7
  AST_HS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid); // R7
  AST_ERR_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop && (in_crc_err || in_stuff_err)) |=> (hs_code == HS_NONE)); // R8

endmodule

// File: rtl/usb_out_rx_engine.sv
module usb_out_rx_engine
  import usb_rx_pkg::*;
#(
  parameter int NUM_BD    = 4,
  parameter int BUF_BYTES = 8,
  localparam int IDX_W    = $clog2(NUM_BD),
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_out,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_eop,
  input  logic              in_crc_err,
  input  logic              in_stuff_err,
  input  logic [1:0]        hs_mode,
  input  logic              arm_valid,
  input  logic [IDX_W-1:0]  arm_idx,
  input  logic              arm_ie,
  input  logic              arm_wrap,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [LEN_W-1:0]  upd_len,
  output logic [2:0]        upd_stat,
  output logic              irq,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic [NUM_BD-1:0] bd_empty,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [7:0]        rd_data,
  output logic [LEN_W-1:0]  rd_len,
  output logic [2:0]        rd_stat
);

  logic [NUM_BD-1:0] bd_ie;
  logic [NUM_BD-1:0] bd_wrap;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [OFF_W-1:0]  mem_off;
  logic [7:0]        mem_data;
  logic              cls_valid;
  logic [IDX_W-1:0]  cls_idx;
  logic [LEN_W-1:0]  cls_len;
  logic [STAT_W-1:0] cls_stat;

  usb_rx_ctrl #(
    .NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_eop(in_eop), .in_crc_err(in_crc_err), .in_stuff_err(in_stuff_err),
    .hs_mode(hs_mode),
    .bd_empty(bd_empty), .bd_ie(bd_ie), .bd_wrap(bd_wrap),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_off(mem_off), .mem_data(mem_data),
    .cls_valid(cls_valid), .cls_idx(cls_idx), .cls_len(cls_len), .cls_stat(cls_stat),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_len(upd_len), .upd_stat(upd_stat),
    .irq(irq), .hs_valid(hs_valid), .hs_code(hs_code)
  );

  usb_rx_bd_table #(
    .NUM_BD(NUM_BD), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .arm_valid(arm_valid), .arm_idx(arm_idx), .arm_ie(arm_ie), .arm_wrap(arm_wrap),
    .cls_valid(cls_valid), .cls_idx(cls_idx), .cls_len(cls_len), .cls_stat(cls_stat),
    .empty_o(bd_empty), .ie_o(bd_ie), .wrap_o(bd_wrap),
    .rd_idx(rd_idx), .rd_len(rd_len), .rd_stat(rd_stat)
  );

  usb_rx_data_mem #(
    .NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_mem (
    .clk(clk), .we(mem_we), .w_idx(mem_idx), .w_off(mem_off), .w_data(mem_data),
    .r_idx(rd_idx), .r_off(rd_off), .r_data(rd_data)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !$past(in_ready)) |-> !upd_valid); // R1

endmodule

// File: tb/tb_usb_out_rx_engine.sv
`timescale 1ns/1ps
module tb_usb_out_rx_engine;

  localparam int NUM_BD = 4;
  localparam int BUF    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_out = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_eop = 1'b0;
  logic       in_crc_err = 1'b0;
  logic       in_stuff_err = 1'b0;
  logic [1:0] hs_mode = 2'b00;
  logic       arm_valid = 1'b0;
  logic [1:0] arm_idx = '0;
  logic       arm_ie = 1'b0;
  logic       arm_wrap = 1'b0;
  logic       upd_valid;
  logic [1:0] upd_idx;
  logic [3:0] upd_len;
  logic [2:0] upd_stat;
  logic       irq;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic [3:0] bd_empty;
  logic [1:0] rd_idx = '0;
  logic [2:0] rd_off = '0;
  logic [7:0] rd_data;
  logic [3:0] rd_len;
  logic [2:0] rd_stat;

  usb_out_rx_engine #(.NUM_BD(NUM_BD), .BUF_BYTES(BUF)) dut (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eop(in_eop),
    .in_crc_err(in_crc_err), .in_stuff_err(in_stuff_err), .hs_mode(hs_mode),
    .arm_valid(arm_valid), .arm_idx(arm_idx), .arm_ie(arm_ie), .arm_wrap(arm_wrap),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_len(upd_len), .upd_stat(upd_stat),
    .irq(irq), .hs_valid(hs_valid), .hs_code(hs_code), .bd_empty(bd_empty),
    .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data), .rd_len(rd_len), .rd_stat(rd_stat)
  );

  always #2 clk = ~clk;

  // Event log filled by the monitor only
  int   nu = 0;
  int   nh = 0;
  int   lg_idx [32];
  int   lg_len [32];
  int   lg_stat[32];
  int   lg_irq [32];
  int   last_hs = -1;
  int   stray_irq = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_valid && nu < 32) begin
        lg_idx[nu]  = int'(upd_idx);
        lg_len[nu]  = int'(upd_len);
        lg_stat[nu] = int'(upd_stat);
        lg_irq[nu]  = int'(irq);
        nu = nu + 1;
      end
      if (irq && !upd_valid) stray_irq = stray_irq + 1;
      if (hs_valid) begin
        nh = nh + 1;
        last_hs = int'(hs_code);
      end
    end
  end

  int n_chk  = 0;
  int n_fail = 0;
  int u0, h0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk_eq(input string what, input int act, input int exp);
    chk(act == exp, what, act, exp);
  endtask

  task automatic arm(input int idx, input bit ie, input bit wr);
    @(negedge clk);
    arm_valid = 1'b1; arm_idx = 2'(idx); arm_ie = ie; arm_wrap = wr;
    @(negedge clk);
    arm_valid = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] base, input bit crc, input bit stf);
    u0 = nu; h0 = nh;
    @(negedge clk) tok_out = 1'b1;
    @(negedge clk) tok_out = 1'b0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data = base + 8'(i);
      in_eop = (i == n - 1);
      in_crc_err = (i == n - 1) && crc;
      in_stuff_err = (i == n - 1) && stf;
      @(negedge clk);
    end
    in_valid = 1'b0; in_eop = 1'b0; in_crc_err = 1'b0; in_stuff_err = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_upd(input string tag, input int k, input int idx, input int len,
                         input int stat, input int irqv);
    chk_eq({tag, " update idx"},  lg_idx[u0 + k],  idx);
    chk_eq({tag, " update len"},  lg_len[u0 + k],  len);
    chk_eq({tag, " update stat"}, lg_stat[u0 + k], stat);
    chk_eq({tag, " update irq"},  lg_irq[u0 + k],  irqv);
  endtask

  task automatic chk_hs(input string tag, input int code);
    chk_eq({tag, " handshake count"}, nh - h0, 1);
    chk_eq({tag, " handshake code"}, last_hs, code);
  endtask

  task automatic rd_byte(input int idx, input int off, output int v);
    rd_idx = 2'(idx); rd_off = 3'(off);
    #1 v = int'(rd_data);
  endtask

  task automatic t_reset;
    chk_eq("R1 reset in_ready", int'(in_ready), 0);
    chk_eq("R1 reset bd_empty", int'(bd_empty), 0);
    chk_eq("R1 reset hs_valid", int'(hs_valid), 0);
    chk_eq("R1 reset upd/irq", int'({upd_valid, irq}), 0);
  endtask

  task automatic t_basic;
    int v;
    arm(0, 1'b1, 1'b0);
    hs_mode = 2'b00;
    chk_eq("R2 armed bd0 empty", int'(bd_empty[0]), 1);
    u0 = nu; h0 = nh;
    @(negedge clk) tok_out = 1'b1;
    @(negedge clk) tok_out = 1'b0;
    chk_eq("R1 ready low during check", int'(in_ready), 0);
    @(negedge clk);
    chk_eq("R1 ready after token", int'(in_ready), 1);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_data = 8'hC3 + 8'(i); in_eop = (i == 4);
      @(negedge clk);
    end
    in_valid = 1'b0; in_eop = 1'b0;
    chk_eq("R1 ready low after eop", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk_eq("R6 basic updates", nu - u0, 1);
    chk_upd("R6 R4 basic", 0, 0, 5, 0, 1);
    chk_hs("R7 ACK", 1);
    rd_byte(0, 0, v); chk_eq("R2 PID byte at offset 0", v, 'hC3);
    rd_byte(0, 4, v); chk_eq("R2 last byte", v, 'hC7);
    chk_eq("R6 stored length", int'(rd_len), 5);
    chk_eq("R3 bd0 handed back", int'(bd_empty[0]), 0);
  endtask

  task automatic t_span;
    int v;
    arm(1, 1'b0, 1'b0);
    arm(2, 1'b1, 1'b0);
    hs_mode = 2'b10;
    send_pkt(12, 8'h10, 1'b0, 1'b0);
    chk_eq("R3 span updates", nu - u0, 2);
    chk_upd("R3 R4 span first", 0, 1, 8, 0, 0);
    chk_upd("R6 R4 span last", 1, 2, 4, 0, 1);
    chk_hs("R7 NAK", 2);
    rd_byte(1, 7, v); chk_eq("R2 end of first slice", v, 'h17);
    rd_byte(2, 0, v); chk_eq("R3 continue at offset 0", v, 'h18);
  endtask

  task automatic t_not_ready;
    hs_mode = 2'b00;
    send_pkt(3, 8'h40, 1'b0, 1'b0);
    chk_eq("R10 no update", nu - u0, 0);
    chk_hs("R10 no handshake", 0);
    chk_eq("R10 table unchanged", int'(bd_empty), 0);
  endtask

  task automatic t_exact;
    arm(3, 1'b1, 1'b0);
    arm(0, 1'b0, 1'b0);
    hs_mode = 2'b11;
    send_pkt(16, 8'h20, 1'b0, 1'b0);
    chk_eq("R11 exact updates", nu - u0, 2);
    chk_upd("R5 R11 exact first", 0, 3, 8, 0, 1);
    chk_upd("R11 exact last", 1, 0, 8, 0, 0);
    chk_hs("R11 R7 STALL", 3);
  endtask

  task automatic t_wrap;
    int v;
    arm(1, 1'b0, 1'b1);
    arm(2, 1'b0, 1'b0);
    arm(0, 1'b1, 1'b0);
    hs_mode = 2'b00;
    send_pkt(10, 8'h60, 1'b0, 1'b0);
    chk_eq("R5 wrap updates", nu - u0, 2);
    chk_upd("R5 wrap first", 0, 1, 8, 0, 0);
    chk_upd("R5 wrap second", 1, 0, 2, 0, 1);
    chk_eq("R5 bd2 skipped", int'(bd_empty[2]), 1);
    rd_byte(0, 1, v); chk_eq("R5 data after wrap", v, 'h69);
    chk_hs("R5 ACK", 1);
  endtask

  task automatic t_errors;
    arm(1, 1'b1, 1'b0);
    hs_mode = 2'b00;
    send_pkt(3, 8'h70, 1'b1, 1'b0);
    chk_eq("R8 crc updates", nu - u0, 1);
    chk_upd("R8 crc", 0, 1, 3, 1, 1);
    chk_hs("R8 crc", 0);
    rd_idx = 2'd1; #1;
    chk_eq("R8 crc stored status", int'(rd_stat), 1);
    send_pkt(4, 8'h74, 1'b0, 1'b1);
    chk_upd("R8 stuff", 0, 2, 4, 2, 0);
    chk_hs("R8 stuff", 0);
  endtask

  task automatic t_overrun;
    arm(3, 1'b0, 1'b0);
    hs_mode = 2'b00;
    send_pkt(11, 8'h80, 1'b0, 1'b0);
    chk_eq("R9 overrun updates", nu - u0, 1);
    chk_upd("R9 overrun", 0, 3, 8, 4, 0);
    chk_hs("R9 overrun", 0);
    chk_eq("R9 nothing left armed", int'(bd_empty), 0);
    chk_eq("R4 irq only with update", stray_irq, 0);
  endtask

  initial begin
    bit timeout = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    fork
      begin
        t_basic();
        t_span();
        t_not_ready();
        t_exact();
        t_wrap();
        t_errors();
        t_overrun();
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule